// File: doc/BRIEF.md
# Range-Clearing Memory Controller

This block wraps a 64-word by 8-bit synchronous RAM with a small controller and datapath that can clear an address window to zero in hardware. In its normal mode the RAM is reached through a plain address bus, a write-data bus, a write strobe and a read-data output. A write, and the address for a read, are both taken on the rising clock edge. The read data then shows the word at that address until the next edge, with no second output register.

Two 6-bit window bounds are captured from the address bus by two separate strobes. A one-cycle clear request starts a sweep. The block raises `busy`, loads a walking counter with the lower bound, and then writes zero at the counter address on every clock. The sweep stops after it has written the location equal to the upper bound, and the block returns to normal mode.

If the lower bound is greater than the upper bound, the counter wraps past the top of memory, so the window runs around the end of the address space. All ports are plain, level-sampled control and data pins with no valid/ready flow control. A caller that wants memory access simply waits for `busy` to be low.

Top module: `memzero_top`

## Requirements
- R1: A synchronous active-high `rst` returns the block to idle with `busy` low and both bounds cleared to 0. A reset taken in the middle of a sweep ends the sweep.
- R2: While idle, `bus_we` high at a rising edge writes `bus_wdata` to `bus_addr`. After each edge, `rd_data` shows the word at the `bus_addr` sampled at that edge, including a word written at that same edge.
- R3: `lo_load` high at an edge copies `bus_addr` into the lower bound, and `hi_load` high at an edge copies it into the upper bound. These loads act independently of the controller.
- R4: `clr_req` high at an edge while idle sets `busy` high from that edge onward.
- R5: A sweep writes 0x00 to every location from the lower bound up to the upper bound, inclusive, and leaves every other location unchanged.
- R6: `busy` stays high for exactly ((HIGH − LOW) mod 64) + 2 cycles: one load cycle plus one write cycle per cleared word. It then falls.
- R7: When LOW > HIGH, the sweep counts upward modulo 64, wrapping from 63 to 0, until it reaches HIGH.
- R8: When LOW = HIGH, exactly one location is cleared and `busy` is high for 2 cycles.
- R9: While `busy` is high, `bus_we` writes nothing and `clr_req` neither restarts nor extends the sweep.
- R10: With LOW = 0 and HIGH = 63, all 64 words are cleared and `busy` is high for 65 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| lo_load | input | 1 | Capture `bus_addr` as the lower window bound |
| hi_load | input | 1 | Capture `bus_addr` as the upper window bound |
| bus_addr | input | 6 | External RAM address, also the source for the bounds |
| bus_wdata | input | 8 | External RAM write data |
| bus_we | input | 1 | External write strobe, honoured only while idle |
| clr_req | input | 1 | Start a window clear, sampled only while idle |
| rd_data | output | 8 | RAM read data for the last sampled address |
| busy | output | 1 | High from the clear request until the sweep ends |

## Verification
The hardest case to reach from the ports is a sweep that is disturbed while it runs. In this case a foreign write and a repeated clear request arrive during the walk, and the request is dropped before the final write so that any restart would show. The bench holds `bus_we` with a data value of 0x77 at an address outside the window, together with `clr_req`, for the first cycles of `busy`. It then checks that `busy` lasts exactly as long as the window predicts, stays low afterwards, and that the outside word is unchanged. A window wrapped across the top of memory and a reset taken partway through a sweep are also driven directly, and all 64 words are read back after each sweep.

// File: rtl/memzero_pkg.sv
package memzero_pkg;

  // One-hot controller state; each bit is used directly as a control line.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'b001,
    ST_LOAD  = 3'b010,
    ST_SWEEP = 3'b100
  } mz_state_t;

  localparam int unsigned N_BOUNDS = 2;
  localparam int unsigned B_LO     = 0;
  localparam int unsigned B_HI     = 1;

endpackage

// File: rtl/mz_bound_regs.sv
module mz_bound_regs #(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lo_load,
  input  logic          hi_load,
  input  logic [AW-1:0] src,
  output logic [AW-1:0] lo_q,
  output logic [AW-1:0] hi_q
);
  import memzero_pkg::*;

  logic [N_BOUNDS-1:0] ld;
  logic [AW-1:0]       bnd [N_BOUNDS];

  assign ld[B_LO] = lo_load;
  assign ld[B_HI] = hi_load;

  for (genvar g = 0; g < N_BOUNDS; g++) begin : g_bound
    always_ff @(posedge clk) begin
      if (rst)        bnd[g] <= '0;
      else if (ld[g]) bnd[g] <= src;
    end
  end

  assign lo_q = bnd[B_LO];
  assign hi_q = bnd[B_HI];
endmodule

// File: rtl/mz_counter.sv
module mz_counter #(
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          en,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  // Up-only counter with synchronous load; it wraps modulo 2**AW.
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
    else if (en)   q <= q + 1'b1;
  end
endmodule

// File: rtl/mz_eq.sv
module mz_eq #(
  parameter int unsigned AW = 6
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  output logic          eq
);
  assign eq = (a == b);
endmodule

// File: rtl/mz_ctrl.sv
module mz_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic clr_req,
  input  logic at_end,
  output logic st_idle,
  output logic st_load,
  output logic st_sweep,
  output logic busy
);
  import memzero_pkg::*;

  mz_state_t state, state_n;
  logic      busy_n;

  always_comb begin
    state_n = state;
    busy_n  = busy;
    unique case (state)
      ST_IDLE: if (clr_req) begin
        state_n = ST_LOAD;
        busy_n  = 1'b1;
      end
      ST_LOAD: state_n = ST_SWEEP;
      ST_SWEEP: if (at_end) begin
        state_n = ST_IDLE;
        busy_n  = 1'b0;
      end
      default: begin
        state_n = ST_IDLE;
        busy_n  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      busy  <= 1'b0;
    end else begin
      state <= state_n;
      busy  <= busy_n;
    end
  end

  // Control lines come straight from state flops.
  assign st_idle  = state[0];
  assign st_load  = state[1];
  assign st_sweep = state[2];
endmodule

// File: rtl/mz_ram.sv
module mz_ram #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    addr_q <= addr;
  end

  assign rdata = mem[addr_q];
endmodule

// File: rtl/memzero_top.sv
module memzero_top #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_load,
  input  logic              hi_load,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              clr_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  logic [ADDR_W-1:0] lo_q, hi_q, cnt_q, ram_addr;
  logic [DATA_W-1:0] ram_wdata;
  logic              ram_we, at_end;
  logic              st_idle, st_load, st_sweep;

  mz_bound_regs #(.AW(ADDR_W)) u_bounds (
    .clk(clk), .rst(rst), .lo_load(lo_load), .hi_load(hi_load),
    .src(bus_addr), .lo_q(lo_q), .hi_q(hi_q)
  );

  mz_counter #(.AW(ADDR_W)) u_cnt (
    .clk(clk), .rst(rst), .load(st_load), .en(st_sweep),
    .d(lo_q), .q(cnt_q)
  );

  mz_eq #(.AW(ADDR_W)) u_eq (.a(cnt_q), .b(hi_q), .eq(at_end));

  mz_ctrl u_ctrl (
    .clk(clk), .rst(rst), .clr_req(clr_req), .at_end(at_end),
    .st_idle(st_idle), .st_load(st_load), .st_sweep(st_sweep), .busy(busy)
  );

  // One select drives both the address and the data multiplexer.
  assign ram_addr  = st_sweep ? cnt_q : bus_addr;
  assign ram_wdata = st_sweep ? '0    : bus_wdata;
  assign ram_we    = (bus_we & st_idle) | st_sweep;

  mz_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(rd_data)
  );
endmodule

// File: rtl/memzero_chk.sv
module memzero_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_req,
  input logic              busy,
  input logic              st_idle,
  input logic              st_load,
  input logic              st_sweep,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [DATA_W-1:0] ram_wdata,
  input logic [ADDR_W-1:0] cnt_q,
  input logic [ADDR_W-1:0] lo_q,
  input logic [ADDR_W-1:0] hi_q
);
  p_start_r4: assert property (@(posedge clk) disable iff (rst)
    (st_idle && clr_req) |=> (busy && st_load));

  p_load_lo_r5: assert property (@(posedge clk) disable iff (rst)
    st_load |=> (st_sweep && cnt_q == $past(lo_q)));

  p_step_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (st_sweep && cnt_q != hi_q) |=> (st_sweep && cnt_q == ADDR_W'($past(cnt_q) + 1'b1)));

  p_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (st_sweep && cnt_q == hi_q) |=> (st_idle && !busy));

  p_zero_write_r5: assert property (@(posedge clk) disable iff (rst)
    st_sweep |-> (ram_we && ram_wdata == '0 && ram_addr == cnt_q));

  p_busy_span_r9: assert property (@(posedge clk) disable iff (rst)
    !st_idle |-> busy);

  p_no_ext_write_r9: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!ram_we || ram_wdata == '0));
endmodule

bind memzero_top memzero_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .clr_req(clr_req), .busy(busy),
  .st_idle(st_idle), .st_load(st_load), .st_sweep(st_sweep),
  .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
  .cnt_q(cnt_q), .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/test_memzero_top.sv
module test_memzero_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lo_load = 1'b0, hi_load = 1'b0, bus_we = 1'b0, clr_req = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] rd_data;
  logic       busy;

  int total = 0;
  int bad   = 0;
  logic [7:0] model [64];

  always #10 clk = ~clk;

  memzero_top i_memzero_top (
    .clk(clk), .rst(rst), .lo_load(lo_load), .hi_load(hi_load),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .clr_req(clr_req), .rd_data(rd_data), .busy(busy)
  );

  // lo, hi, expected busy cycles
  localparam logic [19:0] VEC [5] = '{
    {6'd5,  6'd12, 8'd9},   // R5 normal window
    {6'd20, 6'd20, 8'd2},   // R8 single word
    {6'd60, 6'd3,  8'd9},   // R7 wrapped window
    {6'd0,  6'd63, 8'd65},  // R10 full memory
    {6'd33, 6'd34, 8'd3}    // R5 two words
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
    model[a] = d;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = rd_data;
  endtask

  task automatic fill(input int seed);
    for (int a = 0; a < 64; a++) wr(6'(a), 8'((a * 7 + seed * 29) | 8'h80));
  endtask

  task automatic set_bounds(input logic [5:0] lo, input logic [5:0] hi);
    bus_addr = lo; lo_load = 1'b1;
    @(posedge clk); @(negedge clk);
    lo_load = 1'b0; bus_addr = hi; hi_load = 1'b1;
    @(posedge clk); @(negedge clk);
    hi_load = 1'b0;
  endtask

  function automatic bit in_win(int a, int lo, int hi);
    return ((a - lo) & 63) <= ((hi - lo) & 63);
  endfunction

  task automatic apply_clear(input int lo, input int hi);
    for (int a = 0; a < 64; a++) if (in_win(a, lo, hi)) model[a] = 8'h00;
  endtask

  task automatic check_mem(input string req);
    logic [7:0] d;
    for (int a = 0; a < 64; a++) begin
      rd(6'(a), d);
      chk(req, int'(d), int'(model[a]));
    end
  endtask

  task automatic sweep(output int cyc);
    clr_req = 1'b1;
    @(posedge clk); @(negedge clk);
    clr_req = 1'b0;
    chk("R4 busy after request", int'(busy), 1);
    cyc = 0;
    while (busy && cyc < 300) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 busy low after reset", int'(busy), 0);

    // R2: write then read, including read of the word written at the same edge
    bus_addr = 6'd7; bus_wdata = 8'h3C; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0; model[7] = 8'h3C;
    chk("R2 same-edge readback", int'(rd_data), 8'h3C);
    wr(6'd9, 8'h5A);
    rd(6'd9, d);
    chk("R2 readback", int'(d), 8'h5A);

    // R1: bounds reset to 0, so a clear touches only word 0
    fill(1);
    sweep(cyc);
    chk("R1 busy span with reset bounds", cyc, 2);
    apply_clear(0, 0);
    check_mem("R1 reset bounds clear word 0 only");

    // Table of windows, R3 loads and R5-R8, R10 sweeps
    foreach (VEC[i]) begin
      int lo, hi, eb;
      lo = int'(VEC[i][19:14]); hi = int'(VEC[i][13:8]); eb = int'(VEC[i][7:0]);
      fill(i + 2);
      set_bounds(6'(lo), 6'(hi));
      sweep(cyc);
      chk("R6 busy span", cyc, eb);
      apply_clear(lo, hi);
      check_mem("R3 R5 R7 window contents");
    end

    // R9: foreign write and repeated request during a sweep are ignored
    fill(9);
    set_bounds(6'd10, 6'd20);
    clr_req = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_addr = 6'd40; bus_wdata = 8'h77; bus_we = 1'b1;
    cyc = 0;
    while (busy && cyc < 300) begin
      cyc++;
      if (cyc == 5) clr_req = 1'b0;
      @(negedge clk);
    end
    bus_we = 1'b0;
    chk("R9 busy span unchanged", cyc, 12);
    repeat (3) begin
      chk("R9 no restart", int'(busy), 0);
      @(negedge clk);
    end
    apply_clear(10, 20);
    check_mem("R9 no write while busy");

    // R1: reset in mid-sweep stops the sweep
    set_bounds(6'd0, 6'd63);
    clr_req = 1'b1;
    @(posedge clk); @(negedge clk);
    clr_req = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R1 busy low after mid-sweep reset", int'(busy), 0);
    @(negedge clk);
    chk("R1 stays idle", int'(busy), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule